// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word address for each beat of a four-beat memory burst. On a load cycle it captures a full external address and restarts at beat zero. On an advance cycle it moves to the next beat. Only the two lowest address bits change during a burst, and the bits above them keep the value that was loaded. The order of the low bits depends on a mode pin. Linear order counts up from the seed and wraps modulo four. Interleaved order XORs the seed with the beat number. After the fourth beat the sequence comes back to the loaded address.

An active-low clock enable freezes the whole block, so a stalled cycle looks to the block as if the previous cycle went on longer. The mode pin is meant to be strapped and must not change while bursts are running. The block has no data path and no flow control. Every input is a plain control or address pin that is sampled on the rising clock edge. The output address feeds a memory core directly. Both outputs come straight from registers through a small combinational map, so they change just after the edge that caused the change.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst` is high at a rising edge, `addr_o` and `beat_o` are both zero after that edge, whatever the other inputs are.
- R2: When `clk_en_n` is 0 and `ld_n` is 0 at an edge, `addr_o` equals the sampled `ext_addr` after that edge and `beat_o` is 0.
- R3: When `clk_en_n` is 0 and `ld_n` is 1 at an edge, `beat_o` increments by one modulo 4 (…, 3, 0, …), and `ext_addr` has no effect.
- R4: With `mode_il` = 0 (linear), `addr_o[1:0]` equals (seed + `beat_o`) mod 4, where seed is bits [1:0] of the loaded address.
- R5: With `mode_il` = 1 (interleaved), `addr_o[1:0]` equals seed XOR `beat_o`.
- R6: An advance taken while `beat_o` is 3 brings `addr_o` back to the loaded address, with `beat_o` 0.
- R7: Bits [ADDR_W-1:2] of `addr_o` keep their loaded value during advances. A linear wrap of the low bits from 3 to 0 does not carry into them.
- R8: When `clk_en_n` is 1 at an edge, `addr_o` and `beat_o` keep their values, and `ld_n` and `ext_addr` are ignored.
- R9: A load taken in the middle of a burst (`beat_o` not 0) captures the new address and restarts `beat_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the state |
| ld_n | input | 1 | 0 = load `ext_addr`, 1 = advance to the next beat |
| mode_il | input | 1 | Burst order: 0 = linear, 1 = interleaved (static) |
| ext_addr | input | ADDR_W | External word address sampled on load |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The assertions check on every clock the per-cycle rules:
- clearing on reset;
- capture on load;
- the beat step;
- the freeze under a high clock enable;
- the stability of the upper address bits;
- the return to the loaded address after beat 3.

Only the bench scenarios can show that whole sequences come out right. These are the linear and interleaved address orders from different seeds, a load in the middle of a burst, and a linear wrap that must not carry into the upper bits. They are checked against address values written out by hand.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int unsigned BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // Reset wins over everything, then the clock enable, then load/advance.
  function automatic op_e decode_op(input logic rst, input logic en_n,
                                    input logic ld_n);
    if (rst)       return OP_CLEAR;
    else if (en_n) return OP_HOLD;
    else if (!ld_n) return OP_LOAD;
    else           return OP_STEP;
  endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  op_e   op,
  output beat_t beat
);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR, OP_LOAD: beat <= '0;
      OP_STEP:           beat <= beat + 1'b1;
      default:           beat <= beat;
    endcase
  end

  // R3: one step per advance, modulo four
  p_step_mod4_r3: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_STEP) |=> (beat == beat_t'($past(beat) + 1'b1)));

  // R9: any load restarts the beat index
  p_load_restart_r9: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_LOAD) |=> (beat == '0));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  op_e               op,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base
);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: base <= '0;
      OP_LOAD:  base <= ext_addr;
      default:  base <= base;
    endcase
  end

  // R7/R8: the base address changes only on a load
  p_base_kept_r7: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_STEP || op == OP_HOLD) |=> $stable(base));

endmodule

// File: rtl/burst_lo_map.sv
module burst_lo_map
  import burst_pkg::*;
(
  input  beat_t  seed,
  input  beat_t  beat,
  input  order_e ord,
  output beat_t  lo
);

  beat_t xor_lo;
  beat_t lin_lo;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xbit
    assign xor_lo[i] = seed[i] ^ beat[i];
  end

  assign lin_lo = seed + beat;
  assign lo     = (ord == ORD_XOR) ? xor_lo : lin_lo;

  // R4/R5: beat zero always presents the seed, in either order
  always_comb begin
    if (beat == '0) begin
      p_seed_first_r4: assert (lo == seed);
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              ld_n,
  input  logic              mode_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);

  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  op_e               op;
  beat_t             beat_q;
  beat_t             lo;
  logic [ADDR_W-1:0] base_q;
  order_e            ord;

  assign op  = decode_op(rst, clk_en_n, ld_n);
  assign ord = order_e'(mode_il);

  burst_beat_ctr u_beat (
    .clk  (clk),
    .op   (op),
    .beat (beat_q)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .op       (op),
    .ext_addr (ext_addr),
    .base     (base_q)
  );

  burst_lo_map u_map (
    .seed (base_q[BEAT_W-1:0]),
    .beat (beat_q),
    .ord  (ord),
    .lo   (lo)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], lo};
  assign beat_o = beat_q;

  // R1: reset clears both outputs
  p_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && beat_o == '0));

  // R2: a load presents the sampled address at beat zero
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !ld_n) |=> (addr_o == $past(ext_addr) && beat_o == '0));

  // R8: a high clock enable freezes the outputs
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(addr_o) && $stable(beat_o)));

  // R7: advancing never disturbs the upper address bits
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && ld_n) |=>
      (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  // R6: the beat after the fourth access is the loaded address again
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && ld_n && beat_o == 2'd3) |=>
      (addr_o == base_q && beat_o == '0));

  if (HI_W < 1) begin : g_bad_width
    initial p_width_ok: assert (0);
  end

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

  localparam int AW = 17;

  typedef struct packed {
    logic          en_n;
    logic          ld_n;
    logic          il;
    logic [AW-1:0] a;
    logic [AW-1:0] ea;
    logic [1:0]    eb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b0, 1'b0, 17'h1ABC6, 17'h1ABC6, 2'd0}, // R2 load, seed 2 linear
    '{1'b0, 1'b1, 1'b0, 17'h1FFFF, 17'h1ABC7, 2'd1}, // R4 R3 ext ignored
    '{1'b0, 1'b1, 1'b0, 17'h00000, 17'h1ABC4, 2'd2}, // R4 R7 3->0, no carry
    '{1'b0, 1'b1, 1'b0, 17'h1FFFF, 17'h1ABC5, 2'd3}, // R4
    '{1'b0, 1'b1, 1'b0, 17'h1FFFF, 17'h1ABC6, 2'd0}, // R6 wrap
    '{1'b1, 1'b0, 1'b0, 17'h00000, 17'h1ABC6, 2'd0}, // R8 load ignored
    '{1'b0, 1'b1, 1'b0, 17'h00000, 17'h1ABC7, 2'd1}, // R3
    '{1'b0, 1'b0, 1'b1, 17'h0F0F3, 17'h0F0F3, 2'd0}, // R2 R9 mid-burst load, seed 3 il
    '{1'b0, 1'b1, 1'b1, 17'h1FFFF, 17'h0F0F2, 2'd1}, // R5
    '{1'b0, 1'b1, 1'b1, 17'h1FFFF, 17'h0F0F1, 2'd2}, // R5
    '{1'b1, 1'b1, 1'b1, 17'h1FFFF, 17'h0F0F1, 2'd2}, // R8 advance ignored
    '{1'b0, 1'b1, 1'b1, 17'h1FFFF, 17'h0F0F0, 2'd3}, // R5
    '{1'b0, 1'b1, 1'b1, 17'h1FFFF, 17'h0F0F3, 2'd0}, // R6 wrap il
    '{1'b0, 1'b1, 1'b1, 17'h1FFFF, 17'h0F0F2, 2'd1}, // R3
    '{1'b0, 1'b0, 1'b1, 17'h12345, 17'h12345, 2'd0}, // R9 restart
    '{1'b0, 1'b1, 1'b1, 17'h00000, 17'h12344, 2'd1}  // R5 seed 1
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          ld_n = 1'b1;
  logic          mode_il = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .ld_n     (ld_n),
    .mode_il  (mode_il),
    .ext_addr (ext_addr),
    .addr_o   (addr_o),
    .beat_o   (beat_o)
  );

  task automatic cycle(input logic r, input logic en_n, input logic ld,
                       input logic il, input logic [AW-1:0] a);
    @(negedge clk);
    rst = r; clk_en_n = en_n; ld_n = ld; mode_il = il; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] ea,
                       input logic [1:0] eb);
    total++;
    if (addr_o !== ea || beat_o !== eb) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_o, beat_o, ea, eb);
    end
  endtask

  initial begin
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 17'h1FFFF);
    check("R1 reset state", 17'h00000, 2'd0);

    for (int i = 0; i < NV; i++) begin
      cycle(1'b0, VT[i].en_n, VT[i].ld_n, VT[i].il, VT[i].a);
      check($sformatf("R2-R9 vector %0d", i), VT[i].ea, VT[i].eb);
    end

    // R1: reset mid-burst overrides a load
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 17'h1FFFF);
    check("R1 reset mid-burst", 17'h00000, 2'd0);

    // R7: linear seed 1, low bits 1,2,3,0 with the upper bits staying zero
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 17'h00001);
    check("R2 load seed 1", 17'h00001, 2'd0);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 17'h1FFFC);
    check("R4 linear beat1", 17'h00002, 2'd1);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 17'h1FFFC);
    check("R4 linear beat2", 17'h00003, 2'd2);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 17'h1FFFC);
    check("R7 no carry into upper", 17'h00000, 2'd3);
    // R8: several frozen cycles with loads offered
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 17'h15555);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 17'h0AAAA);
    check("R8 long freeze", 17'h00000, 2'd3);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 17'h15555);
    check("R6 wrap after freeze", 17'h00001, 2'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule